// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Driver

This block generates the four gate signals of a full-bridge converter in which the two legs switch at a fixed 50% duty and output power is set by the phase angle between them. A free-running time base defines the switching period. The left leg is the phase reference. The right leg runs from the same time base, moved by an offset that comes from a signed fractional phase command. Each leg drives a complementary high/low pair, and each leg has its own dead-time setting, so the switches of one leg are never on together.

A control loop elsewhere writes the phase command, the two 4-bit dead-time counts and a shared dead-time scale code. The block holds these values in shadow registers and takes new ones only at the end of a period. A pulse that has already started is therefore never cut short or stretched by an update. With the default period of 750 clocks, a 150 MHz clock gives 200 kHz switching.

Top module: `psfb_gate_driver`

## Requirements
- R1: The time base repeats every PERIOD clocks (default 750). Each leg's high-side gate is high for PERIOD/2 − D clocks per period and its low-side gate for PERIOD − PERIOD/2 − D clocks, where D is that leg's dead time.
- R2: The left-leg high-side gate falls at a fixed point of the time base in every period, whatever the settings.
- R3: The phase command is signed two's complement with 15 fraction bits (0x7FFF ≈ +180°, 0x3FFF ≈ +90°, 0xC000 = −90°, 0x8000 = −180°). The offset in clocks is floor(phase × (PERIOD/2) / 32768). The rising edge of the right high-side gate follows the rising edge of the left high-side gate by (offset mod PERIOD) + Dright − Dleft clocks, taken modulo PERIOD.
- R4: A negative phase command makes the right leg lead the left leg. Its offset is wrapped into the range 0..PERIOD−1 (for example, −90° becomes PERIOD − 188 with the default period).
- R5: Dead time in clocks is the 4-bit count shifted left by the scale code bits [4:2]. Values 0 to 5 give factors 1 to 32 (codes 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14). Values 6 and 7 act as 5. Bits [1:0] are ignored.
- R6: A dead-time count of 0 gives zero dead time at every scale setting.
- R7: The left and right legs use their own dead-time counts independently.
- R8: The high-side and low-side gates of a leg are never high in the same cycle.
- R9: The phase, dead-time and scale inputs take effect only at the period boundary. A change made in the middle of a period does not alter that period's edges.
- R10: While reset is asserted, all four gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_cmd | input | 16 | Signed Q15 phase of the right leg relative to the left leg |
| db_left | input | 4 | Left-leg dead-time count |
| db_right | input | 4 | Right-leg dead-time count |
| db_scale | input | 5 | Shared dead-time scale code |
| gate_lh | output | 1 | Left leg high-side gate |
| gate_ll | output | 1 | Left leg low-side gate |
| gate_rh | output | 1 | Right leg high-side gate |
| gate_rl | output | 1 | Right leg low-side gate |

## Verification
A wrong time-base count or a wrong offset shows up within one period. Pulse widths change, or the delay from a left rising edge to the next right rising edge moves away from the value computed from the command. A dead-band age counter that fails to restart or to saturate shows up at the next edge of that leg. Either the gap between one gate falling and its partner rising takes the wrong length, or the two gates overlap. A shadow register that loads at the wrong time shows up in the same period that the inputs change, because the gap after the next falling edge then uses the new dead time instead of the old one.

// File: rtl/psfb_gate_driver.sv
module psfb_gate_driver #(
  parameter int PERIOD    = 750,
  parameter int PH_W      = 16,
  parameter int DB_W      = 4,
  parameter int SC_W      = 5,
  parameter int MAX_SHIFT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_cmd,
  input  logic [DB_W-1:0] db_left,
  input  logic [DB_W-1:0] db_right,
  input  logic [SC_W-1:0] db_scale,
  output logic            gate_lh,
  output logic            gate_ll,
  output logic            gate_rh,
  output logic            gate_rl
);
  localparam int HALF = PERIOD / 2;
  localparam int CW   = $clog2(PERIOD);
  localparam int FRAC = PH_W - 1;
  localparam int PW   = PH_W + CW + 2;
  localparam int SW   = SC_W - 2;
  localparam int DTW  = DB_W + MAX_SHIFT;

  logic [CW-1:0]          cnt;
  logic signed [PH_W-1:0] sh_phase;
  logic [DB_W-1:0]        sh_db [2];
  logic [SC_W-1:0]        sh_sc;
  logic                   wrap;

  assign wrap = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh_phase <= '0;
      sh_db[0] <= '0;
      sh_db[1] <= '0;
      sh_sc    <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        sh_phase <= $signed(phase_cmd);
        sh_db[0] <= db_left;
        sh_db[1] <= db_right;
        sh_sc    <= db_scale;
      end
    end
  end

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] off;
  logic [CW-1:0]        rcnt;

  assign prod = sh_phase * $signed({2'b00, CW'(HALF)});
  assign off  = prod >>> FRAC;

  always_comb begin
    int o;
    int r;
    o = int'(off);
    if (o < 0) o = o + PERIOD;
    r = int'(cnt) - o;
    if (r < 0) r = r + PERIOD;
    rcnt = CW'(r);
  end

  logic [SW-1:0] shift;
  assign shift = (int'(sh_sc[SC_W-1:2]) > MAX_SHIFT) ? SW'(MAX_SHIFT) : sh_sc[SC_W-1:2];

  logic raw [2];
  logic hi  [2];
  logic lo  [2];

  assign raw[0] = (cnt  < CW'(HALF));
  assign raw[1] = (rcnt < CW'(HALF));

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic           rq;
    logic [CW-1:0]  age;
    logic [DTW-1:0] dt;

    assign dt = DTW'(sh_db[g]) << shift;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rq    <= 1'b0;
        age   <= '0;
        hi[g] <= 1'b0;
        lo[g] <= 1'b0;
      end else begin
        hi[g] <= rq  && (int'(age) >= int'(dt));
        lo[g] <= !rq && (int'(age) >= int'(dt));
        if (raw[g] != rq) begin
          rq  <= raw[g];
          age <= '0;
        end else if (age != '1) begin
          age <= age + 1'b1;
        end
      end
    end
  end

  assign gate_lh = hi[0];
  assign gate_ll = lo[0];
  assign gate_rh = hi[1];
  assign gate_rl = lo[1];
endmodule

// File: rtl/psfb_gate_chk.sv
module psfb_gate_chk #(
  parameter int PERIOD = 750,
  parameter int PH_W   = 16,
  parameter int SC_W   = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(PERIOD)-1:0] cnt,
  input logic signed [PH_W-1:0] sh_phase,
  input logic [SC_W-1:0]        sh_sc,
  input logic                   gate_lh,
  input logic                   gate_ll,
  input logic                   gate_rh,
  input logic                   gate_rl
);
  localparam int CW   = $clog2(PERIOD);
  localparam int FALL = (PERIOD / 2 + 2) % PERIOD;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < PERIOD);

  assert_left_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_lh) |-> cnt == CW'(FALL));

  assert_no_overlap_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lh && gate_ll));

  assert_no_overlap_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_rh && gate_rl));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(sh_phase) && $stable(sh_sc)));

  always_comb begin
    if (rst_n == 1'b0) begin
      assert_reset_low_R10: assert (!gate_lh && !gate_ll && !gate_rh && !gate_rl);
    end
  end
endmodule

bind psfb_gate_driver psfb_gate_chk #(.PERIOD(PERIOD), .PH_W(PH_W), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .sh_phase(sh_phase), .sh_sc(sh_sc),
  .gate_lh(gate_lh), .gate_ll(gate_ll), .gate_rh(gate_rh), .gate_rl(gate_rl)
);

// File: tb/tb_psfb_gate_driver.sv
module tb_psfb_gate_driver;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 750;
  localparam int HALF = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] phase_cmd = '0;
  logic [3:0]  db_left = '0, db_right = '0;
  logic [4:0]  db_scale = '0;
  logic gate_lh, gate_ll, gate_rh, gate_rl;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  psfb_gate_driver #(.PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .phase_cmd(phase_cmd), .db_left(db_left),
    .db_right(db_right), .db_scale(db_scale), .gate_lh(gate_lh),
    .gate_ll(gate_ll), .gate_rh(gate_rh), .gate_rl(gate_rl));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog (all) actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dead(logic [3:0] n, logic [4:0] sc);
    int s = int'(sc[4:2]);
    if (s > 5) s = 5;
    return int'(n) << s;
  endfunction

  function automatic int offs(logic [15:0] ph);
    longint p = longint'($signed(ph));
    longint o = (p * HALF) >>> 15;
    if (o < 0) o = o + P;
    return int'(o);
  endfunction

  task automatic apply(logic [15:0] ph, logic [3:0] dl, logic [3:0] dr, logic [4:0] sc);
    phase_cmd = ph; db_left = dl; db_right = dr; db_scale = sc;
    repeat (2*P + 5) @(negedge clk);
  endtask

  task automatic measure(output int nlh, output int nll, output int nrh,
                         output int nrl, output int ov, output int lag);
    logic plh, prh;
    int guard = 0;
    nlh = 0; nll = 0; nrh = 0; nrl = 0; ov = 0; lag = -1;
    @(negedge clk); plh = gate_lh; prh = gate_rh;
    while (!(gate_lh && !plh) && guard < 2*P) begin
      plh = gate_lh; prh = gate_rh; @(negedge clk); guard++;
    end
    for (int t = 0; t < P; t++) begin
      if (gate_rh && !prh && lag < 0) lag = t;
      nlh += int'(gate_lh); nll += int'(gate_ll);
      nrh += int'(gate_rh); nrl += int'(gate_rl);
      if ((gate_lh && gate_ll) || (gate_rh && gate_rl)) ov++;
      prh = gate_rh;
      @(negedge clk);
    end
  endtask

  task automatic scenario(string req, logic [15:0] ph, logic [3:0] dl,
                          logic [3:0] dr, logic [4:0] sc, bit chk_lag);
    int a, b, c, d, ov, lag, dlc, drc;
    apply(ph, dl, dr, sc);
    measure(a, b, c, d, ov, lag);
    dlc = dead(dl, sc); drc = dead(dr, sc);
    chk({req, " R1"}, "left high width", a, HALF - dlc);
    chk({req, " R1"}, "left low width", b, P - HALF - dlc);
    chk({req, " R7"}, "right high width", c, HALF - drc);
    chk({req, " R7"}, "right low width", d, P - HALF - drc);
    chk({req, " R8"}, "overlap cycles", ov, 0);
    if (chk_lag) chk({req, " R3"}, "right lag", lag, (offs(ph) + drc - dlc + P) % P);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R10", "gates in reset", int'({gate_lh, gate_ll, gate_rh, gate_rl}), 0);
    rst_n = 1'b1;
  endtask

  task automatic gap_after_fall(output int g);
    @(negedge clk);
    while (gate_lh) @(negedge clk);
    g = 0;
    while (!gate_ll && g < P) begin g++; @(negedge clk); end
  endtask

  task automatic test_boundary;
    int g;
    apply(16'h0000, 4'd0, 4'd0, 5'h00);
    @(negedge clk);
    while (!gate_lh) @(negedge clk);
    db_left = 4'd15;
    gap_after_fall(g);
    chk("R9", "gap in same period", g, 0);
    while (!gate_lh) @(negedge clk);
    gap_after_fall(g);
    chk("R9", "gap next period", g, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    scenario("R6 zero", 16'h0000, 4'd0, 4'd0, 5'h00, 1);
    scenario("R3 +90", 16'h3FFF, 4'd5, 4'd3, 5'h04, 1);
    scenario("R4 -90", 16'hC000, 4'd0, 4'd0, 5'h00, 1);
    scenario("R3 +180", 16'h7FFF, 4'd2, 4'd4, 5'h00, 1);
    scenario("R4 -180", 16'h8000, 4'd1, 4'd0, 5'h08, 1);
    scenario("R5 x32", 16'h0000, 4'd10, 4'd1, 5'h14, 1);
    scenario("R5 clamp", 16'h0000, 4'd2, 4'd5, 5'h1F, 0);
    scenario("R5 lowbits", 16'h2000, 4'd3, 4'd7, 5'h07, 1);
    scenario("R6 dbt0 x32", 16'h1000, 4'd0, 4'd0, 5'h14, 1);
    test_boundary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule